// File: doc/BRIEF.md
# Vectored Prioritized Interrupt Controller

This block gathers 32 level-sensitive interrupt lines and steers each one to a processor core as either a fast interrupt or a normal interrupt. Each line can be masked and classified independently. Software can also raise any line by setting a bit in a software-request word. All enabled fast-class requests are ORed onto the fast output. All enabled normal-class requests are ORed onto the normal output.

Sixteen priority slots can each be bound to any source and given a service-routine address. A read of the vector word returns the address held by the lowest-numbered slot whose source is a pending normal request. If no slot qualifies, the read returns a shared default address.

A vector read latches the winning slot as in service. Until software writes the acknowledge word, that slot and every lower-priority slot are hidden from the vector read. Only a slot with a smaller number can preempt it.

Top module: `vic_core`

## Requirements
- R1: The effective request of source n is `irq_in[n]` ORed with bit n of the software-request word (offset 0x18, read/write). The raw word at offset 0x08 returns every effective request, whatever the enable and class settings.
- R2: A class bit of 1 in the class word (offset 0x0C) makes source n fast. `fiq_o` is high exactly when some enabled fast-class source has an effective request.
- R3: `irq_o` is high exactly when some enabled normal-class source (class bit 0) has an effective request. Offset 0x00 returns the enabled normal-class requests and offset 0x04 the enabled fast-class requests.
- R4: Writing ones to offset 0x10 sets the matching enable bits, and writing ones to offset 0x14 clears them. Zero bits leave enables unchanged. A read of offset 0x10 returns the enable mask.
- R5: Slot k has an address word at 0x100+4k and a control word at 0x200+4k, where bits 4:0 hold the source number and bit 8 the slot enable. A read of offset 0x30 returns the address of the lowest-numbered qualifying slot. A slot qualifies when it is enabled and its source is enabled, normal-class and requesting.
- R6: When no slot qualifies, a read of offset 0x30 returns the default address held at offset 0x34 (read/write).
- R7: A vector read that finds a qualifying slot latches it as in service. While a slot is latched, that slot and all higher-numbered slots are ignored by later vector reads. A lower-numbered slot still wins and replaces the latch.
- R8: Any write to offset 0x38 ends service and releases the latch.
- R9: After reset, every register reads zero and both interrupt outputs are low.
- R10: Only full-word accesses (`bus_be` = 4'hF, address bits 1:0 zero) take effect. Other writes change nothing, and other reads return zero with no side effect.
- R11: Reads of unmapped offsets return zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 32 | Hardware interrupt request lines, level sensitive |
| bus_sel | input | 1 | Register access strobe for this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset of the register |
| bus_be | input | 4 | Byte enables; only 4'hF is honoured |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as the read |
| fiq_o | output | 1 | Fast interrupt to the core |
| irq_o | output | 1 | Normal interrupt to the core |

## Verification
The assertions assume at most one register access per cycle, with address, byte enables and data held steady through the clock edge. They also assume reset is asserted from time zero. The bench meets these assumptions by driving every input on the falling edge, one access per call, and keeping reset low for several cycles before any access. The random phase draws offsets only from the mapped set plus a few unmapped and misaligned ones. It draws byte enables that are mostly full-word, so partial accesses occur without starving the vector and acknowledge paths.

// File: rtl/vic_core.sv
module vic_core #(
  parameter int NSRC  = 32,
  parameter int NSLOT = 16,
  parameter int AW    = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] irq_in,
  input  logic            bus_sel,
  input  logic            bus_wr,
  input  logic [AW-1:0]   bus_addr,
  input  logic [3:0]      bus_be,
  input  logic [31:0]     bus_wdata,
  output logic [31:0]     bus_rdata,
  output logic            fiq_o,
  output logic            irq_o
);
  // NSRC <= 32, NSLOT <= 32
  localparam int SW = $clog2(NSRC);
  localparam int KW = $clog2(NSLOT);
  localparam logic [AW-1:0] A_NST = 'h00, A_FST = 'h04, A_RAW = 'h08, A_CLS = 'h0C,
                            A_ENS = 'h10, A_ENC = 'h14, A_SFT = 'h18, A_VEC = 'h30,
                            A_DEF = 'h34, A_ACK = 'h38;

  logic [NSRC-1:0] en_q, cls_q, soft_q;
  logic [SW-1:0]   src_q [NSLOT];
  logic [NSLOT-1:0] on_q;
  logic [31:0]     vec_q [NSLOT];
  logic [31:0]     dflt_q;
  logic            act_v;
  logic [KW-1:0]   act_s;

  wire [NSRC-1:0] req   = irq_in | soft_q;
  wire [NSRC-1:0] fstat = req & en_q & cls_q;
  wire [NSRC-1:0] nstat = req & en_q & ~cls_q;
  assign fiq_o = |fstat;
  assign irq_o = |nstat;

  wire acc    = bus_sel && bus_be == 4'hF && bus_addr[1:0] == 2'b00;
  wire wr     = acc && bus_wr;
  wire rd     = acc && !bus_wr;
  wire sok    = {1'b0, bus_addr[7:2]} < 7'(NSLOT);
  wire in_vr  = sok && bus_addr[AW-1:8] == (AW-8)'(1);
  wire in_cr  = sok && bus_addr[AW-1:8] == (AW-8)'(2);
  wire [KW-1:0] sidx = bus_addr[2 +: KW];
  wire [NSRC-1:0] wd = bus_wdata[NSRC-1:0];
  wire rd_vec = rd && bus_addr == A_VEC;

  logic          hit;
  logic [KW-1:0] win_s;
  always_comb begin
    hit   = 1'b0;
    win_s = '0;
    for (int i = NSLOT - 1; i >= 0; i--)
      if (on_q[i] && nstat[src_q[i]] && (!act_v || KW'(i) < act_s)) begin
        hit   = 1'b1;
        win_s = KW'(i);
      end
  end

  always_comb begin
    bus_rdata = '0;
    if (rd) begin
      if (in_vr) bus_rdata = vec_q[sidx];
      else if (in_cr) begin
        bus_rdata    = 32'(src_q[sidx]);
        bus_rdata[8] = on_q[sidx];
      end else
        case (bus_addr)
          A_NST: bus_rdata = 32'(nstat);
          A_FST: bus_rdata = 32'(fstat);
          A_RAW: bus_rdata = 32'(req);
          A_CLS: bus_rdata = 32'(cls_q);
          A_ENS: bus_rdata = 32'(en_q);
          A_SFT: bus_rdata = 32'(soft_q);
          A_VEC: bus_rdata = hit ? vec_q[win_s] : dflt_q;
          A_DEF: bus_rdata = dflt_q;
          default: bus_rdata = '0;
        endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q <= '0; cls_q <= '0; soft_q <= '0; dflt_q <= '0;
      on_q <= '0; act_v <= 1'b0; act_s <= '0;
      for (int i = 0; i < NSLOT; i++) begin
        src_q[i] <= '0;
        vec_q[i] <= '0;
      end
    end else if (wr) begin
      if (in_vr) vec_q[sidx] <= bus_wdata;
      else if (in_cr) begin
        src_q[sidx] <= bus_wdata[SW-1:0];
        on_q[sidx]  <= bus_wdata[8];
      end else
        case (bus_addr)
          A_CLS: cls_q  <= wd;
          A_ENS: en_q   <= en_q | wd;
          A_ENC: en_q   <= en_q & ~wd;
          A_SFT: soft_q <= wd;
          A_DEF: dflt_q <= bus_wdata;
          A_ACK: act_v  <= 1'b0;
          default: ;
        endcase
    end else if (rd_vec && hit) begin
      act_v <= 1'b1;
      act_s <= win_s;
    end
  end

  AST_ENABLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    wr && bus_addr == A_ENC |=> (en_q & $past(bus_wdata[NSRC-1:0])) == '0); // R4
  AST_PARTIAL_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    bus_sel && bus_wr && bus_be != 4'hF |=> $stable(en_q) && $stable(cls_q) && $stable(soft_q) && $stable(dflt_q)); // R10
  AST_DEFAULT_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_vec && !irq_o |-> bus_rdata == dflt_q); // R6
  AST_LATCH_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rd_vec && hit |=> act_v); // R7
  AST_LATCH_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    act_v && !rd_vec && !(wr && bus_addr == A_ACK) |=> act_v && $stable(act_s)); // R7
  AST_ACK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    wr && bus_addr == A_ACK |=> !act_v); // R8
endmodule

// File: tb/vic_core_test.sv
`timescale 1ns/1ps
module vic_core_test;
  logic clk = 0, rst_n = 0;
  logic [31:0] irq_in = '0, nx_irq = '0;
  logic bus_sel = 0, bus_wr = 0;
  logic [11:0] bus_addr = '0;
  logic [3:0] bus_be = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic fiq_o, irq_o;
  int checks = 0, errors = 0;
  bit done = 0;

  vic_core uut (.clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .fiq_o(fiq_o), .irq_o(irq_o));

  always #2.5 clk = ~clk;

  logic [31:0] m_en = 0, m_cls = 0, m_soft = 0, m_dflt = 0;
  logic [31:0] m_vec [16];
  int m_src [16];
  bit m_on [16];
  bit m_av = 0;
  int m_as = 0;

  function automatic logic [31:0] m_nst();
    return (irq_in | m_soft) & m_en & ~m_cls;
  endfunction

  function automatic int m_win();
    logic [31:0] n = m_nst();
    for (int s = 0; s < 16; s++)
      if (m_on[s] && n[m_src[s]] && (!m_av || s < m_as)) return s;
    return -1;
  endfunction

  function automatic logic [31:0] exp_read(logic [11:0] a, logic [3:0] b);
    int w;
    if (b != 4'hF || a[1:0] != 0) return 0;
    if (a[11:8] == 1 && a[7:2] < 16) return m_vec[a[5:2]];
    if (a[11:8] == 2 && a[7:2] < 16) return 32'(m_src[a[5:2]]) | (m_on[a[5:2]] ? 32'h100 : 0);
    case (a)
      12'h00: return m_nst();
      12'h04: return (irq_in | m_soft) & m_en & m_cls;
      12'h08: return irq_in | m_soft;
      12'h0C: return m_cls;
      12'h10: return m_en;
      12'h18: return m_soft;
      12'h30: begin w = m_win(); return w >= 0 ? m_vec[w] : m_dflt; end
      12'h34: return m_dflt;
      default: return 0;
    endcase
  endfunction

  task automatic m_update(bit s, bit w, logic [11:0] a, logic [3:0] b, logic [31:0] d);
    int k;
    if (!s || b != 4'hF || a[1:0] != 0) return;
    if (w) begin
      if (a[11:8] == 1 && a[7:2] < 16) m_vec[a[5:2]] = d;
      else if (a[11:8] == 2 && a[7:2] < 16) begin m_src[a[5:2]] = int'(d[4:0]); m_on[a[5:2]] = d[8]; end
      else case (a)
        12'h0C: m_cls = d;
        12'h10: m_en = m_en | d;
        12'h14: m_en = m_en & ~d;
        12'h18: m_soft = d;
        12'h34: m_dflt = d;
        12'h38: m_av = 0;
        default: ;
      endcase
    end else if (a == 12'h30) begin
      k = m_win();
      if (k >= 0) begin m_av = 1; m_as = k; end
    end
  endtask

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h at %0t", r, act, exp, $time);
    end
  endtask

  task automatic cyc(bit s, bit w, logic [11:0] a, logic [3:0] b, logic [31:0] d, string t);
    @(negedge clk);
    irq_in = nx_irq; bus_sel = s; bus_wr = w; bus_addr = a; bus_be = b; bus_wdata = d;
    #1;
    if (rst_n) begin
      chk("R2", 32'(fiq_o), 32'(|((irq_in | m_soft) & m_en & m_cls)));
      chk("R3", 32'(irq_o), 32'(|m_nst()));
      if (s && !w) chk(t, bus_rdata, exp_read(a, b));
    end
    @(posedge clk);
    if (rst_n) m_update(s, w, a, b, d);
  endtask

  task automatic wr32(logic [11:0] a, logic [31:0] d); cyc(1, 1, a, 4'hF, d, ""); endtask
  task automatic rd32(logic [11:0] a, string t); cyc(1, 0, a, 4'hF, 0, t); endtask

  function automatic string tag_of(logic [11:0] a, logic [3:0] b);
    if (b != 4'hF || a[1:0] != 0) return "R10";
    if (a[11:8] == 1 || a[11:8] == 2) return "R5";
    case (a)
      12'h00, 12'h04: return "R3";
      12'h08, 12'h18: return "R1";
      12'h0C: return "R2";
      12'h10: return "R4";
      12'h30: return "R7";
      12'h34: return "R6";
      default: return "R11";
    endcase
  endfunction

  initial begin
    for (int i = 0; i < 16; i++) begin m_vec[i] = 0; m_src[i] = 0; m_on[i] = 0; end
    repeat (4) @(posedge clk);
    @(negedge clk); bus_sel = 1; bus_wr = 0; bus_be = 4'hF; bus_addr = 12'h10; #1;
    chk("R9", bus_rdata, 0);
    chk("R9", {30'b0, fiq_o, irq_o}, 0);
    @(negedge clk); rst_n = 1; bus_sel = 0;
    rd32(12'h0C, "R9");
    rd32(12'h30, "R9");

    nx_irq = 32'h0000_0060;
    wr32(12'h18, 32'h0000_0005);
    rd32(12'h08, "R1");
    rd32(12'h00, "R1");
    wr32(12'h10, 32'h0000_00FF);
    wr32(12'h0C, 32'h0000_000F);
    rd32(12'h04, "R2");
    rd32(12'h00, "R3");
    wr32(12'h14, 32'h0000_0003);
    rd32(12'h10, "R4");
    wr32(12'h10, 32'h0000_0000);
    rd32(12'h10, "R4");

    for (int s = 0; s < 16; s++) wr32(12'h100 + 12'(4 * s), 32'h1000 + 32'(s) * 32'h10);
    wr32(12'h34, 32'hDEAD_0000);
    wr32(12'h208, 32'h105);
    wr32(12'h21C, 32'h106);
    wr32(12'h200, 32'h114);
    rd32(12'h208, "R5");
    rd32(12'h30, "R5");
    rd32(12'h30, "R7");
    nx_irq = 32'h0010_0060;
    wr32(12'h10, 32'h0010_0000);
    rd32(12'h30, "R7");
    rd32(12'h30, "R7");
    wr32(12'h38, 0);
    rd32(12'h30, "R8");
    wr32(12'h38, 0);
    nx_irq = 32'h0000_0060;
    rd32(12'h30, "R8");
    wr32(12'h38, 0);
    nx_irq = 0;
    wr32(12'h18, 0);
    rd32(12'h30, "R6");

    cyc(1, 1, 12'h10, 4'h3, 32'hFFFF_FFFF, "");
    rd32(12'h10, "R10");
    cyc(1, 1, 12'h11, 4'hF, 32'hFFFF_FFFF, "");
    rd32(12'h10, "R10");
    cyc(1, 0, 12'h34, 4'h1, 0, "R10");
    wr32(12'h40, 32'h1234_5678);
    rd32(12'h40, "R11");
    rd32(12'h1C, "R11");

    for (int n = 0; n < 3000; n++) begin
      logic [11:0] a;
      logic [3:0] b;
      int pick = int'($urandom_range(0, 15));
      if ($urandom_range(0, 7) == 0) nx_irq = $urandom;
      case (pick)
        0: a = 12'h00; 1: a = 12'h04; 2: a = 12'h08; 3: a = 12'h0C;
        4: a = 12'h10; 5: a = 12'h14; 6: a = 12'h18; 7, 8: a = 12'h30;
        9: a = 12'h34; 10: a = 12'h38;
        11: a = 12'h100 + 12'(4 * $urandom_range(0, 15));
        12, 13: a = 12'h200 + 12'(4 * $urandom_range(0, 15));
        14: a = 12'h3C;
        default: a = 12'(4 * $urandom_range(0, 1023)) | 12'($urandom_range(0, 3));
      endcase
      b = ($urandom_range(0, 9) == 0) ? 4'($urandom) : 4'hF;
      cyc(1, $urandom_range(0, 1) == 1, a, b, $urandom, tag_of(a, b));
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule